// File: doc/BRIEF.md
# Stream Configuration Entry Locator

This block turns a stream identifier into the memory address of that stream's 64-byte configuration entry and reads the entry in. It works from a small set of configuration inputs: the table base address, a flag that selects a flat table or a two-level table, the bit position at which a stream identifier is split into two indices, and the number of identifier bits the system implements. The block issues reads one at a time over a simple valid/ready request channel with a separate response channel. Each response carries a 64-bit data word and an error flag.

With a flat table, the entry sits directly at the base plus the identifier times 64. With a two-level table, the upper part of the identifier selects an 8-byte first-level descriptor. That descriptor holds a pointer to a second-level table and a span field that gives the size of that table. The lower part of the identifier then selects the entry inside it. The entry comes back as a 512-bit word together with a one-cycle done pulse. If a check or a read fails, the block instead gives a one-cycle fault pulse with a fault code and the address involved.

Top module: `stream_entry_locator`

## Requirements
- R1: After reset, `busy`, `out_done`, `out_fault` and `mem_req_valid` are all low.
- R2: A request whose identifier has any bit set at or above position `cfg_id_bits` gives a fault with code 1 (bad stream) and fault address 0 in the next cycle. No memory request is made for it.
- R3: In flat mode the entry address is (`cfg_base` with bits [5:0] cleared) plus identifier times 64. It is read as 8 requests at entry+8k for k = 0..7, and beat k lands in `out_entry[64k+63:64k]`. `out_done` pulses in the cycle after the last response.
- R4: In two-level mode, one read is first made at (`cfg_base` with bits [5:0] cleared) plus (identifier >> `cfg_split`) times 8.
- R5: The first-level descriptor holds the span in bits [4:0] and the second-level pointer in bits [47:6], with bits [5:0] of the pointer taken as zero. The entry address is that pointer plus (identifier & (2^`cfg_split` − 1)) times 64, and the entry is then read as in R3.
- R6: A descriptor with span 0 gives fault code 1 (bad stream), with the descriptor address as fault address. This takes priority over R7.
- R7: A low index greater than 2^span − 1 gives fault code 2 (bad entry), with the descriptor address as fault address, and no entry read is made.
- R8: An error response on the descriptor read gives fault code 3 (fetch), with the descriptor address as fault address. An error on any entry beat gives code 3 with the entry base address, and no further beats are requested.
- R9: At most one read is outstanding. A request that is not yet accepted keeps its address stable until it is accepted.
- R10: `out_done` and `out_fault` are exclusive one-cycle pulses, after which `busy` is low. A `req_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 48 | Table base address (bits [5:0] ignored) |
| cfg_two_level | input | 1 | 1 selects the two-level table |
| cfg_split | input | 5 | Bit position splitting the identifier |
| cfg_id_bits | input | 5 | Implemented identifier width |
| req_valid | input | 1 | Start a lookup (sampled when not busy) |
| req_sid | input | 16 | Stream identifier |
| busy | output | 1 | Lookup in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 48 | Read byte address (8-byte aligned) |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response error |
| out_done | output | 1 | Entry ready pulse |
| out_entry | output | 512 | Assembled entry |
| out_fault | output | 1 | Fault pulse |
| out_fault_code | output | 2 | 1 bad stream, 2 bad entry, 3 fetch |
| out_fault_addr | output | 48 | Address tied to the fault |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted request, and that it never raises a response while no request is outstanding. They also assume that the configuration inputs stay fixed while `busy` is high. The bench's responder records every accepted request and answers it after a programmable latency, with an optional ready stall pattern. Configuration changes happen only between lookups. A second `req_valid` during a lookup is the only stimulus that touches the block while it is busy.

// File: rtl/sel_pkg.sv
package sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_ENT_REQ,
        ST_ENT_WAIT,
        ST_DONE,
        ST_FAULT
    } sel_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_BAD_SID   = 2'd1,
        FLT_BAD_ENTRY = 2'd2,
        FLT_FETCH     = 2'd3
    } sel_fault_e;

endpackage

// File: rtl/sel_addr_gen.sv
// Address arithmetic for both table layouts.
module sel_addr_gen #(
    parameter int AW        = 48,
    parameter int SID_W     = 16,
    parameter int IDX_W     = 5,
    parameter int L1_SHIFT  = 3,
    parameter int ENT_SHIFT = 6
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] split,
    input  logic [SID_W-1:0] sid,
    input  logic [AW-1:0]    desc,
    output logic [AW-1:0]    l1_addr,
    output logic [AW-1:0]    lin_addr,
    output logic [AW-1:0]    l2_addr,
    output logic [SID_W-1:0] l2_idx
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ENT_SHIFT) - AW'(1));

    logic [AW-1:0]    base_al;
    logic [AW-1:0]    l2_ptr;
    logic [SID_W-1:0] l1_idx;
    logic [SID_W:0]   split_bit;
    logic [SID_W:0]   low_mask;

    assign base_al   = base & ALIGN_MASK;
    assign l2_ptr    = desc & ALIGN_MASK;
    assign l1_idx    = sid >> split;
    assign split_bit = (SID_W+1)'(1) << split;
    assign low_mask  = split_bit - (SID_W+1)'(1);
    assign l2_idx    = sid & low_mask[SID_W-1:0];

    assign l1_addr  = base_al + (AW'(l1_idx) << L1_SHIFT);
    assign lin_addr = base_al + (AW'(sid) << ENT_SHIFT);
    assign l2_addr  = l2_ptr + (AW'(l2_idx) << ENT_SHIFT);
endmodule

// File: rtl/sel_checks.sv
// Range checks on the identifier and on the second-level index.
module sel_checks #(
    parameter int SID_W  = 16,
    parameter int IDX_W  = 5,
    parameter int SPAN_W = 5
) (
    input  logic [SID_W-1:0]  sid,
    input  logic [IDX_W-1:0]  id_bits,
    input  logic [SPAN_W-1:0] span,
    input  logic [SID_W-1:0]  l2_idx,
    output logic              sid_ok,
    output logic              span_zero,
    output logic              l2_ok
);
    assign sid_ok    = (sid >> id_bits) == '0;
    assign span_zero = span == '0;
    assign l2_ok     = (l2_idx >> span) == '0;
endmodule

// File: rtl/sel_beat_store.sv
// Collects the entry beats into one wide register, one slice per beat.
module sel_beat_store #(
    parameter int BEAT_W  = 64,
    parameter int BEATS   = 8,
    parameter int BEAT_IW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [BEAT_IW-1:0]      idx,
    input  logic [BEAT_W-1:0]       data,
    output logic [BEAT_W*BEATS-1:0] entry
);
    for (genvar b = 0; b < BEATS; b++) begin : g_slice
        logic [BEAT_W-1:0] slice_d, slice_q;

        always_comb begin
            slice_d = slice_q;
            if (wr && (idx == BEAT_IW'(b))) begin
                slice_d = data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slice_q <= '0;
            end else begin
                slice_q <= slice_d;
            end
        end

        assign entry[b*BEAT_W +: BEAT_W] = slice_q;
    end
endmodule

// File: rtl/stream_entry_locator.sv
module stream_entry_locator
    import sel_pkg::*;
#(
    parameter int AW     = 48,
    parameter int SID_W  = 16,
    parameter int IDX_W  = $clog2(SID_W + 1),
    parameter int SPAN_W = 5,
    parameter int BEAT_W = 64,
    parameter int BEATS  = 8,
    parameter int L1_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           cfg_base,
    input  logic                    cfg_two_level,
    input  logic [IDX_W-1:0]        cfg_split,
    input  logic [IDX_W-1:0]        cfg_id_bits,
    input  logic                    req_valid,
    input  logic [SID_W-1:0]        req_sid,
    output logic                    busy,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [AW-1:0]           mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [BEAT_W-1:0]       mem_rsp_data,
    input  logic                    mem_rsp_err,
    output logic                    out_done,
    output logic [BEAT_W*BEATS-1:0] out_entry,
    output logic                    out_fault,
    output logic [1:0]              out_fault_code,
    output logic [AW-1:0]           out_fault_addr
);
    localparam int BEAT_BYTES = BEAT_W / 8;
    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
    localparam int ENT_SHIFT  = $clog2(BEAT_BYTES * BEATS);
    localparam int L1_SHIFT   = $clog2(L1_BYTES);
    localparam int BEAT_IW    = $clog2(BEATS);

    typedef struct packed {
        sel_state_e         st;
        logic [SID_W-1:0]   sid;
        logic [AW-1:0]      l1_addr;
        logic [AW-1:0]      ent_addr;
        logic [BEAT_IW-1:0] beat;
        sel_fault_e         code;
        logic [AW-1:0]      faddr;
    } regs_t;

    regs_t r_d, r_q;
    sel_state_e st_q;

    logic [SID_W-1:0] sid_sel;
    logic [AW-1:0]    l1_addr_w, lin_addr_w, l2_addr_w;
    logic [SID_W-1:0] l2_idx_w;
    logic             sid_ok_w, span_zero_w, l2_ok_w;
    logic             beat_wr;

    assign st_q    = r_q.st;
    assign sid_sel = (r_q.st == ST_IDLE) ? req_sid : r_q.sid;

    sel_addr_gen #(
        .AW(AW), .SID_W(SID_W), .IDX_W(IDX_W),
        .L1_SHIFT(L1_SHIFT), .ENT_SHIFT(ENT_SHIFT)
    ) u_addr (
        .base     (cfg_base),
        .split    (cfg_split),
        .sid      (sid_sel),
        .desc     (mem_rsp_data[AW-1:0]),
        .l1_addr  (l1_addr_w),
        .lin_addr (lin_addr_w),
        .l2_addr  (l2_addr_w),
        .l2_idx   (l2_idx_w)
    );

    sel_checks #(
        .SID_W(SID_W), .IDX_W(IDX_W), .SPAN_W(SPAN_W)
    ) u_chk (
        .sid       (sid_sel),
        .id_bits   (cfg_id_bits),
        .span      (mem_rsp_data[SPAN_W-1:0]),
        .l2_idx    (l2_idx_w),
        .sid_ok    (sid_ok_w),
        .span_zero (span_zero_w),
        .l2_ok     (l2_ok_w)
    );

    sel_beat_store #(
        .BEAT_W(BEAT_W), .BEATS(BEATS), .BEAT_IW(BEAT_IW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (beat_wr),
        .idx   (r_q.beat),
        .data  (mem_rsp_data),
        .entry (out_entry)
    );

    always_comb begin
        r_d           = r_q;
        beat_wr       = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.sid   = req_sid;
                    r_d.code  = FLT_NONE;
                    r_d.faddr = '0;
                    r_d.beat  = '0;
                    if (!sid_ok_w) begin
                        r_d.code = FLT_BAD_SID;
                        r_d.st   = ST_FAULT;
                    end else if (cfg_two_level) begin
                        r_d.l1_addr = l1_addr_w;
                        r_d.st      = ST_L1_REQ;
                    end else begin
                        r_d.ent_addr = lin_addr_w;
                        r_d.st       = ST_ENT_REQ;
                    end
                end
            end
            ST_L1_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = r_q.l1_addr;
                if (mem_req_ready) begin
                    r_d.st = ST_L1_WAIT;
                end
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.faddr = r_q.l1_addr;
                    if (mem_rsp_err) begin
                        r_d.code = FLT_FETCH;
                        r_d.st   = ST_FAULT;
                    end else if (span_zero_w) begin
                        r_d.code = FLT_BAD_SID;
                        r_d.st   = ST_FAULT;
                    end else if (!l2_ok_w) begin
                        r_d.code = FLT_BAD_ENTRY;
                        r_d.st   = ST_FAULT;
                    end else begin
                        r_d.faddr    = '0;
                        r_d.ent_addr = l2_addr_w;
                        r_d.beat     = '0;
                        r_d.st       = ST_ENT_REQ;
                    end
                end
            end
            ST_ENT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = r_q.ent_addr + (AW'(r_q.beat) << BEAT_SHIFT);
                if (mem_req_ready) begin
                    r_d.st = ST_ENT_WAIT;
                end
            end
            ST_ENT_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        r_d.code  = FLT_FETCH;
                        r_d.faddr = r_q.ent_addr;
                        r_d.st    = ST_FAULT;
                    end else begin
                        beat_wr = 1'b1;
                        if (r_q.beat == BEAT_IW'(BEATS - 1)) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.beat = r_q.beat + BEAT_IW'(1);
                            r_d.st   = ST_ENT_REQ;
                        end
                    end
                end
            end
            ST_DONE:  r_d.st = ST_IDLE;
            ST_FAULT: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, code: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy           = r_q.st != ST_IDLE;
    assign out_done       = r_q.st == ST_DONE;
    assign out_fault      = r_q.st == ST_FAULT;
    assign out_fault_code = r_q.code;
    assign out_fault_addr = r_q.faddr;
endmodule

// File: rtl/sel_checker.sv
module sel_checker
    import sel_pkg::*;
#(
    parameter int AW    = 48,
    parameter int SID_W = 16,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [SID_W-1:0] req_sid,
    input logic [IDX_W-1:0] cfg_id_bits,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             mem_rsp_err,
    input logic             out_done,
    input logic             out_fault,
    input logic [1:0]       out_fault_code,
    input sel_state_e       st
);
    assert_bad_sid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && ((req_sid >> cfg_id_bits) != '0))
        |=> (out_fault && out_fault_code == 2'd1 && !mem_req_valid));

    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

    assert_l1_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L1_WAIT && mem_rsp_valid && mem_rsp_err)
        |=> (out_fault && out_fault_code == 2'd3));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_L1_WAIT || st == ST_ENT_WAIT) |-> !mem_req_valid);

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_done, out_fault}));

    assert_idle_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done || out_fault) |=> !busy);
endmodule

bind stream_entry_locator sel_checker #(
    .AW(AW), .SID_W(SID_W), .IDX_W(IDX_W)
) u_sel_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_sid        (req_sid),
    .cfg_id_bits    (cfg_id_bits),
    .busy           (busy),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_err    (mem_rsp_err),
    .out_done       (out_done),
    .out_fault      (out_fault),
    .out_fault_code (out_fault_code),
    .st             (st_q)
);

// File: tb/tb_stream_entry_locator.sv
`timescale 1ns/1ps
module tb_stream_entry_locator;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [47:0]  cfg_base = '0;
    logic         cfg_two_level = 1'b0;
    logic [4:0]   cfg_split = '0;
    logic [4:0]   cfg_id_bits = 5'd16;
    logic         req_valid = 1'b0;
    logic [15:0]  req_sid = '0;
    logic         busy;
    logic         mem_req_valid;
    logic         mem_req_ready;
    logic [47:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [63:0]  mem_rsp_data;
    logic         mem_rsp_err;
    logic         out_done;
    logic [511:0] out_entry;
    logic         out_fault;
    logic [1:0]   out_fault_code;
    logic [47:0]  out_fault_addr;

    always #5 clk = ~clk;

    stream_entry_locator dut (.*);

    // ---------------- memory model ----------------
    logic [63:0] l1_tab [0:255];
    logic [47:0] err_addr = 48'hFFFF_FFFF_FFF8;
    int          lat_cfg = 0;
    bit          stall = 1'b0;
    bit          clr = 1'b0;
    logic        pend;
    logic [47:0] pend_addr;
    int          lat;
    logic        tog;
    logic [47:0] req_log [0:15];
    int          nreq;

    function automatic logic [63:0] memval(input logic [47:0] a);
        if (a >= 48'h1000 && a < 48'h1800) return l1_tab[(a - 48'h1000) >> 3];
        return {16'hBEEF, a};
    endfunction

    function automatic logic [511:0] exp_entry(input logic [47:0] a);
        logic [511:0] e;
        for (int k = 0; k < 8; k++) e[k*64 +: 64] = memval(a + 48'(8 * k));
        return e;
    endfunction

    assign mem_req_ready = !pend && !(stall && tog);

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
            mem_rsp_err <= 1'b0; nreq <= 0; tog <= 1'b0; lat <= 0; pend_addr <= '0;
        end else begin
            tog <= ~tog;
            mem_rsp_valid <= 1'b0;
            if (clr) nreq <= 0;
            if (mem_req_valid && mem_req_ready) begin
                pend <= 1'b1; pend_addr <= mem_req_addr; lat <= lat_cfg;
                if (nreq < 16) req_log[nreq] <= mem_req_addr;
                nreq <= nreq + 1;
            end else if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= memval(pend_addr);
                    mem_rsp_err   <= (pend_addr == err_addr);
                    pend <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_fail = 0;
    logic         got_done, got_fault, busy_after, pulse_after;
    logic [1:0]   got_code;
    logic [47:0]  got_faddr;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_entry(input string rq, input logic [47:0] a);
        logic [511:0] e;
        e = exp_entry(a);
        n_checks++;
        if (out_entry !== e) begin
            n_fail++;
            $display("FAIL %s entry: actual %h expected %h", rq, out_entry, e);
        end
    endtask

    task automatic do_req(input logic [15:0] sid, input bit intrude);
        @(negedge clk); req_valid = 1'b1; req_sid = sid; clr = 1'b1;
        @(negedge clk); req_valid = 1'b0; clr = 1'b0;
        got_done = 1'b0; got_fault = 1'b0; got_code = '0; got_faddr = '0;
        for (int i = 0; i < 400; i++) begin
            if (intrude && i == 3) begin req_valid = 1'b1; req_sid = 16'h0009; end
            else req_valid = 1'b0;
            if (out_done || out_fault) begin
                got_done = out_done; got_fault = out_fault;
                got_code = out_fault_code; got_faddr = out_fault_addr;
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        @(negedge clk);
        pulse_after = out_done | out_fault;
        busy_after  = busy;
    endtask

    task automatic expect_done(input string rq, input logic [47:0] ent, input int first);
        chk(got_done && !got_fault, rq, "done pulse", {62'd0, got_done, got_fault}, 64'd2);
        chk(nreq == first + 8, rq, "request count", 64'(nreq), 64'(first + 8));
        for (int k = 0; k < 8; k++)
            if (req_log[first + k] !== ent + 48'(8 * k))
                chk(1'b0, rq, "beat address", 64'(req_log[first + k]), 64'(ent + 48'(8 * k)));
        chk_entry(rq, ent);
    endtask

    task automatic expect_fault(input string rq, input logic [1:0] code,
                                input logic [47:0] fa, input int reqs);
        chk(got_fault && !got_done, rq, "fault pulse", {62'd0, got_done, got_fault}, 64'd1);
        chk(got_code == code, rq, "fault code", 64'(got_code), 64'(code));
        chk(got_faddr == fa, rq, "fault addr", 64'(got_faddr), 64'(fa));
        chk(nreq == reqs, rq, "request count", 64'(nreq), 64'(reqs));
    endtask

    task automatic t_reset();
        chk(!busy && !out_done && !out_fault && !mem_req_valid, "R1", "reset outputs",
            {60'd0, busy, out_done, out_fault, mem_req_valid}, 64'd0);
    endtask

    task automatic t_linear();
        cfg_two_level = 1'b0; cfg_base = 48'h40025; cfg_id_bits = 5'd8;
        do_req(16'd5, 1'b0);   expect_done("R3", 48'h40140, 0);
        do_req(16'd0, 1'b0);   expect_done("R3", 48'h40000, 0);
        do_req(16'd255, 1'b0); expect_done("R3", 48'h43FC0, 0);
    endtask

    task automatic t_range();
        cfg_two_level = 1'b0; cfg_base = 48'h40000; cfg_id_bits = 5'd4;
        do_req(16'd16, 1'b0);  expect_fault("R2", 2'd1, 48'h0, 0);
        do_req(16'd15, 1'b0);  expect_done("R2", 48'h403C0, 0);
        cfg_id_bits = 5'd16;
        do_req(16'hFFFF, 1'b0); expect_done("R2", 48'h40000 + (48'hFFFF << 6), 0);
    endtask

    task automatic t_two_level();
        cfg_two_level = 1'b1; cfg_base = 48'h1000; cfg_split = 5'd4; cfg_id_bits = 5'd8;
        do_req(16'h23, 1'b0);
        chk(req_log[0] == 48'h1010, "R4", "descriptor address", 64'(req_log[0]), 64'h1010);
        expect_done("R5", 48'h800C0, 1);
        do_req(16'h27, 1'b0);  expect_done("R5", 48'h801C0, 1);
        cfg_split = 5'd0;
        do_req(16'h02, 1'b0);
        chk(req_log[0] == 48'h1010, "R4", "split 0 descriptor", 64'(req_log[0]), 64'h1010);
        expect_done("R5", 48'h80000, 1);
        cfg_split = 5'd4;
    endtask

    task automatic t_span_zero();
        cfg_two_level = 1'b1; cfg_base = 48'h1000; cfg_split = 5'd4;
        do_req(16'h12, 1'b0);  expect_fault("R6", 2'd1, 48'h1008, 1);
        do_req(16'h10, 1'b0);  expect_fault("R6", 2'd1, 48'h1008, 1);
    endtask

    task automatic t_bad_entry();
        cfg_two_level = 1'b1; cfg_base = 48'h1000; cfg_split = 5'd4;
        do_req(16'h34, 1'b0);  expect_fault("R7", 2'd2, 48'h1018, 1);
        do_req(16'h33, 1'b0);  expect_done("R7", 48'h900C0, 1);
        do_req(16'h28, 1'b0);  expect_fault("R7", 2'd2, 48'h1010, 1);
    endtask

    task automatic t_fetch_err();
        cfg_two_level = 1'b1; cfg_base = 48'h1000; cfg_split = 5'd4;
        err_addr = 48'h1010;
        do_req(16'h23, 1'b0);  expect_fault("R8", 2'd3, 48'h1010, 1);
        cfg_two_level = 1'b0; cfg_base = 48'h40000; cfg_id_bits = 5'd8;
        err_addr = 48'h40140 + 48'd24;
        do_req(16'd5, 1'b0);   expect_fault("R8", 2'd3, 48'h40140, 4);
        err_addr = 48'hFFFF_FFFF_FFF8;
    endtask

    task automatic t_stall();
        cfg_two_level = 1'b1; cfg_base = 48'h1000; cfg_split = 5'd4; cfg_id_bits = 5'd8;
        stall = 1'b1; lat_cfg = 3;
        do_req(16'h23, 1'b0);  expect_done("R9", 48'h800C0, 1);
        stall = 1'b0; lat_cfg = 0;
    endtask

    task automatic t_busy_ignore();
        cfg_two_level = 1'b0; cfg_base = 48'h40000; cfg_id_bits = 5'd8;
        do_req(16'd5, 1'b1);
        expect_done("R10", 48'h40140, 0);
        chk(!pulse_after && !busy_after, "R10", "idle after pulse",
            {62'd0, pulse_after, busy_after}, 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) l1_tab[i] = 64'd0;
        l1_tab[1] = 64'h0000_0000_0007_0000;   // span 0, pointer ignored
        l1_tab[2] = 64'h0000_0000_0008_0003;   // pointer 0x80000, span 3
        l1_tab[3] = 64'h0000_0000_0009_0022;   // pointer 0x90000, bit 5 ignored, span 2
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_range();
        t_two_level();
        t_span_zero();
        t_bad_entry();
        t_fetch_err();
        t_stall();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule